// File: doc/BRIEF.md
# Timer Count Core

This block is the counting heart of one timer channel. It picks one of eight count sources, either one of five prescaled clock-enable pulses or one of three external clock lines. It can invert the chosen source and gate it with an external burst line. It then advances a 16-bit up-counter once per active edge of the result. Every flop runs on the system clock. The external lines are brought in through a two-flop synchronizer and an edge detector, so the counter never sees a second clock domain.

Counting is governed by two independent latches. The enable latch is set and cleared by commands, and a disable always wins. The start latch is set by a trigger and cleared by a stop event, and both only while the channel is enabled. A trigger does not zero the counter at once. The clear is folded into the next active source edge. Wrapping from all-ones to zero produces a one-cycle overflow pulse for a sticky status flag kept elsewhere. The surrounding channel logic supplies the select fields, the command pulses and the trigger, stop and disable events. It reads the count, the enable status and the overflow pulse.

Top module: `tmr_count_core`

## Requirements
- R1: `srcSel` codes 0 to 4 select `divEn[0]` to `divEn[4]`, and codes 5, 6 and 7 select `extIn[0]`, `extIn[1]` and `extIn[2]`. Activity on an unselected source never changes the count.
- R2: An external line passes through a two-flop synchronizer. Each rising edge of a line that holds each level for at least two system-clock cycles yields exactly one count.
- R3: With `clkInvert` = 1 the counter advances on the 1-to-0 transition of the selected source and not on its 0-to-1 transition.
- R4: `burstSel` = 0 applies no gating. Codes 1, 2 and 3 AND the synchronized `extIn[0]`, `extIn[1]` or `extIn[2]` with the (possibly inverted) source, and no count occurs while that gate line is low.
- R5: `cmdEnable` sets the enable latch only if `cmdDisable` is low in the same cycle, and `cmdDisable` clears it. `clkEnSts` shows the latch one cycle after the command.
- R6: While the enable latch is clear and no enable command is present, `trigIn` and `stopEvt` are ignored. The start latch keeps its value, so re-enabling resumes counting if it was started.
- R7: An accepted trigger sets the start latch and schedules a clear. The counter keeps its value until the next active tick, and that tick loads 0 instead of incrementing.
- R8: `stopEvt` while enabled clears the start latch and halts counting. A trigger in the same cycle wins and the channel is started.
- R9: A tick at the all-ones count (0xFFFF at the default width) gives 0 and raises `ovfPulse` for exactly one cycle, the cycle in which the counter reads 0.
- R10: After reset the count is 0, `clkEnSts` is 0, `ovfPulse` is 0 and the channel is not started.
- R11: `disEvt` clears the enable latch exactly as `cmdDisable` does, and it also overrides a same-cycle `cmdEnable`.
- R12: The counter advances only on ticks while both the enable latch and the start latch are set. Enable alone never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divEn | input | 5 | Prescaled clock-enable pulses, synchronous to clk |
| extIn | input | 3 | Asynchronous external clock lines |
| srcSel | input | 3 | Count source select |
| clkInvert | input | 1 | Count on falling edge of the source |
| burstSel | input | 2 | Burst gate select (0 none, 1..3 external line) |
| cmdEnable | input | 1 | Enable command pulse |
| cmdDisable | input | 1 | Disable command pulse |
| trigIn | input | 1 | Trigger pulse (any trigger source) |
| stopEvt | input | 1 | Stop event pulse |
| disEvt | input | 1 | Disable event pulse |
| cntVal | output | 16 | Current count |
| clkEnSts | output | 1 | Enable latch state |
| ovfPulse | output | 1 | One-cycle wrap indication |

## Verification
The assertions check several properties on every cycle. The edge detector never gives two ticks in a row. A disable of either kind leaves the enable latch clear. The start latch is frozen while the channel is disabled, and it follows accepted triggers and stops. The count holds whenever no count strobe is issued, and an overflow pulse always sits on a zero count. The bench scenarios cover the parts that depend on the stimulus history: the source mapping code by code, falling-edge counting, burst gating, the deferred clear after a trigger, that ignored triggers and stops leave no trace once the channel is re-enabled, and the exact cycle of the wrap.

// File: rtl/tmr_count_pkg.sv
package tmr_count_pkg;
  // strobes issued by the control to the counter datapath
  typedef struct packed {
    logic countEn;   // advance (or clear) on this cycle
    logic clearCnt;  // load zero instead of incrementing
  } cnt_strobe_t;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int N_DIV       = 5,
  parameter int N_EXT       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(N_DIV + N_EXT),
  parameter int BURST_W     = $clog2(N_EXT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_DIV-1:0]   divEn,
  input  logic [N_EXT-1:0]   extIn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               clkInvert,
  input  logic [BURST_W-1:0] burstSel,
  output logic               tick
);
  localparam int N_SRC = N_DIV + N_EXT;
  localparam logic [SEL_W:0] N_SRC_W = (SEL_W + 1)'(N_SRC);

  logic [N_EXT-1:0] extSync;
  logic [N_SRC-1:0] srcVec;
  logic             selLvl;
  logic             burstOk;
  logic             gatedLvl;
  logic             gatedQ;
  logic [BURST_W-1:0] burstIdx;

  // two-or-more flop synchronizer per external line
  for (genvar g = 0; g < N_EXT; g++) begin : gSync
    logic [SYNC_STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg <= '0;
      else       stg <= {stg[SYNC_STAGES-2:0], extIn[g]};
    end
    assign extSync[g] = stg[SYNC_STAGES-1];
  end

  assign srcVec   = {extSync, divEn};
  assign burstIdx = burstSel - BURST_W'(1);

  always_comb begin
    selLvl = 1'b0;
    if ({1'b0, srcSel} < N_SRC_W) selLvl = srcVec[srcSel];
  end

  always_comb begin
    burstOk = 1'b1;
    if (burstSel != '0) burstOk = extSync[burstIdx];
  end

  assign gatedLvl = (selLvl ^ clkInvert) & burstOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gatedQ <= 1'b0;
    else       gatedQ <= gatedLvl;
  end

  assign tick = gatedLvl & ~gatedQ;

  // R2: the edge detector cannot fire on two consecutive cycles
  a_r2_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/tmr_count_ctrl.sv
module tmr_count_ctrl
  import tmr_count_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        cmdEnable,
  input  logic        cmdDisable,
  input  logic        trigIn,
  input  logic        stopEvt,
  input  logic        disEvt,
  output cnt_strobe_t strobe,
  output logic        clkEnSts
);
  logic enLatch, enNext;
  logic runLatch, runNext;
  logic clrPend;
  logic trigOk, stopOk;
  logic killEn;

  assign killEn = cmdDisable | disEvt;
  assign enNext = (enLatch | cmdEnable) & ~killEn;
  assign trigOk = trigIn & enNext;
  assign stopOk = stopEvt & enNext & ~trigOk;

  always_comb begin
    runNext = runLatch;
    if (trigOk)      runNext = 1'b1;
    else if (stopOk) runNext = 1'b0;
  end

  assign strobe.countEn  = tick & enLatch & runLatch;
  assign strobe.clearCnt = strobe.countEn & (clrPend | trigOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLatch  <= 1'b0;
      runLatch <= 1'b0;
      clrPend  <= 1'b0;
    end else begin
      enLatch  <= enNext;
      runLatch <= runNext;
      if (strobe.countEn) clrPend <= 1'b0;
      else if (trigOk)    clrPend <= 1'b1;
    end
  end

  assign clkEnSts = enLatch;

  // R5: a disable command always leaves the latch clear
  a_r5_dis_wins: assert property (@(posedge clk) disable iff (!rstN)
    cmdDisable |=> !clkEnSts);
  // R11: a disable event behaves like the command
  a_r11_evt_dis: assert property (@(posedge clk) disable iff (!rstN)
    disEvt |=> !clkEnSts);
  // R6: start latch frozen while disabled
  a_r6_run_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!enLatch && !cmdEnable) |=> $stable(runLatch));
  // R7: accepted trigger starts the clock
  a_r7_trig_starts: assert property (@(posedge clk) disable iff (!rstN)
    (trigIn && enLatch && !killEn) |=> runLatch);
  // R8: stop without trigger halts while enabled
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    (stopEvt && !trigIn && enLatch && !killEn) |=> !runLatch);
endmodule

// File: rtl/tmr_count_dp.sv
module tmr_count_dp
  import tmr_count_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      ovfPulse <= 1'b0;
    end else begin
      ovfPulse <= strobe.countEn & ~strobe.clearCnt & (cnt == CNT_MAX);
      if (strobe.clearCnt)     cnt <= '0;
      else if (strobe.countEn) cnt <= cnt + CNT_W'(1);
    end
  end

  assign cntVal = cnt;

  // R12: no strobe, no movement
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countEn |=> $stable(cnt));
  // R9: the wrap pulse always accompanies a zero count
  a_r9_ovf_zero: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (cnt == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_count_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_DIV       = 5,
  parameter int N_EXT       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(N_DIV + N_EXT),
  parameter int BURST_W     = $clog2(N_EXT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_DIV-1:0]   divEn,
  input  logic [N_EXT-1:0]   extIn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               clkInvert,
  input  logic [BURST_W-1:0] burstSel,
  input  logic               cmdEnable,
  input  logic               cmdDisable,
  input  logic               trigIn,
  input  logic               stopEvt,
  input  logic               disEvt,
  output logic [CNT_W-1:0]   cntVal,
  output logic               clkEnSts,
  output logic               ovfPulse
);
  logic        tick;
  cnt_strobe_t strobe;

  tmr_src_sel #(
    .N_DIV(N_DIV), .N_EXT(N_EXT), .SYNC_STAGES(SYNC_STAGES),
    .SEL_W(SEL_W), .BURST_W(BURST_W)
  ) uSrc (
    .clk(clk), .rstN(rstN), .divEn(divEn), .extIn(extIn),
    .srcSel(srcSel), .clkInvert(clkInvert), .burstSel(burstSel),
    .tick(tick)
  );

  tmr_count_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .trigIn(trigIn),
    .stopEvt(stopEvt), .disEvt(disEvt),
    .strobe(strobe), .clkEnSts(clkEnSts)
  );

  tmr_count_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntVal(cntVal), .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/tb_tmr_count_core.sv
module tb_tmr_count_core;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] divEn = '0;
  logic [2:0] extIn = '0;
  logic [2:0] srcSel = '0;
  logic clkInvert = 1'b0;
  logic [1:0] burstSel = '0;
  logic cmdEnable = 1'b0, cmdDisable = 1'b0, trigIn = 1'b0;
  logic stopEvt = 1'b0, disEvt = 1'b0;
  logic [CW-1:0] cntVal;
  logic clkEnSts, ovfPulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { int kind; int exp; string tag; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_count_core #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .divEn(divEn), .extIn(extIn),
    .srcSel(srcSel), .clkInvert(clkInvert), .burstSel(burstSel),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .trigIn(trigIn),
    .stopEvt(stopEvt), .disEvt(disEvt),
    .cntVal(cntVal), .clkEnSts(clkEnSts), .ovfPulse(ovfPulse)
  );

  // kind 0 = count, 1 = enable status, 2 = overflow pulse
  task automatic pushExp(input int kind, input int exp, input string tag);
    exp_t e;
    e.kind = kind; e.exp = exp; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops and compares shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        int act;
        e = q.pop_front();
        case (e.kind)
          0:       act = int'(cntVal);
          1:       act = int'(clkEnSts);
          default: act = int'(ovfPulse);
        endcase
        checks++;
        if (act != e.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d", e.tag, e.kind, act, e.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tickDiv(input int i);
    @(negedge clk); divEn[i] = 1'b1;
    @(negedge clk); divEn[i] = 1'b0;
    idle(2);
  endtask

  task automatic pulseExt(input int i);
    @(negedge clk); extIn[i] = 1'b1;
    idle(4);
    extIn[i] = 1'b0;
    idle(4);
  endtask

  task automatic doCmd(input logic en, input logic dis, input logic trg,
                       input logic stp, input logic dev);
    @(negedge clk);
    cmdEnable = en; cmdDisable = dis; trigIn = trg; stopEvt = stp; disEvt = dev;
    @(negedge clk);
    cmdEnable = 0; cmdDisable = 0; trigIn = 0; stopEvt = 0; disEvt = 0;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    pushExp(0, 0, "R10 count after reset");
    pushExp(1, 0, "R10 status after reset");
    pushExp(2, 0, "R10 overflow after reset");

    doCmd(1, 0, 0, 0, 0);
    pushExp(1, 1, "R5 enable command sets status");
    tickDiv(0); tickDiv(0);
    pushExp(0, 0, "R12 enabled but not started does not count");

    doCmd(0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) tickDiv(0);
    pushExp(0, 5, "R12 counts with both latches set");
    doCmd(0, 0, 1, 0, 0);
    idle(2);
    pushExp(0, 5, "R7 value held until next tick after trigger");
    tickDiv(0);
    pushExp(0, 0, "R7 tick after trigger loads zero");

    @(negedge clk); srcSel = 3'd2;
    tickDiv(0);
    pushExp(0, 0, "R1 unselected divEn0 ignored");
    tickDiv(2);
    pushExp(0, 1, "R1 code 2 selects divEn2");
    @(negedge clk); srcSel = 3'd4;
    tickDiv(4);
    pushExp(0, 2, "R1 code 4 selects divEn4");
    @(negedge clk); srcSel = 3'd5;
    pulseExt(0);
    pushExp(0, 3, "R1 code 5 selects extIn0");
    pulseExt(1);
    pushExp(0, 3, "R1 unselected extIn1 ignored");
    @(negedge clk); srcSel = 3'd7;
    pulseExt(2);
    pushExp(0, 4, "R1 code 7 selects extIn2");

    @(negedge clk); srcSel = 3'd6;
    pulseExt(1); pulseExt(1); pulseExt(1);
    pushExp(0, 7, "R2 one count per synchronized extIn1 edge");

    // invert: reconfigure while stopped, then restart
    @(negedge clk); srcSel = 3'd0;
    doCmd(0, 0, 0, 1, 0);
    @(negedge clk); clkInvert = 1'b1;
    idle(2);
    doCmd(0, 0, 1, 0, 0);
    @(negedge clk); divEn[0] = 1'b1;
    idle(3);
    pushExp(0, 7, "R3 no count on rising edge when inverted");
    divEn[0] = 1'b0;
    idle(3);
    pushExp(0, 0, "R3 falling edge tick applies pending clear");
    @(negedge clk); divEn[0] = 1'b1;
    idle(3);
    divEn[0] = 1'b0;
    idle(3);
    pushExp(0, 1, "R3 counts on falling edge");

    @(negedge clk); clkInvert = 1'b0; burstSel = 2'd1;
    idle(2);
    tickDiv(0);
    pushExp(0, 1, "R4 gate extIn0 low blocks counting");
    @(negedge clk); extIn[0] = 1'b1;
    idle(4);
    tickDiv(0);
    pushExp(0, 2, "R4 gate extIn0 high passes counting");
    @(negedge clk); extIn[0] = 1'b0;
    idle(4);
    burstSel = 2'd0;
    idle(2);

    doCmd(0, 0, 0, 1, 0);
    tickDiv(0);
    pushExp(0, 2, "R8 stop halts counting");
    doCmd(0, 0, 1, 1, 0);
    tickDiv(0);
    tickDiv(0);
    pushExp(0, 1, "R8 trigger wins over same-cycle stop");

    doCmd(0, 1, 0, 0, 0);
    pushExp(1, 0, "R5 disable clears status");
    tickDiv(0);
    pushExp(0, 1, "R6 disabled does not count");
    doCmd(0, 0, 1, 0, 0);
    doCmd(0, 0, 0, 1, 0);
    doCmd(1, 0, 0, 0, 0);
    tickDiv(0);
    pushExp(0, 2, "R6 trigger and stop ignored while disabled");

    doCmd(1, 1, 0, 0, 0);
    pushExp(1, 0, "R5 disable wins over same-cycle enable");
    tickDiv(0);
    pushExp(0, 2, "R5 no count after disable wins");
    doCmd(1, 0, 0, 0, 0);
    pushExp(1, 1, "R5 enable alone sets status");
    tickDiv(0);
    pushExp(0, 3, "R6 re-enable resumes started channel");

    doCmd(1, 0, 0, 0, 1);
    pushExp(1, 0, "R11 disable event clears status over enable");
    tickDiv(0);
    pushExp(0, 3, "R11 no count after disable event");
    doCmd(1, 0, 0, 0, 0);

    doCmd(0, 0, 1, 0, 0);
    tickDiv(0);
    for (int i = 0; i < MAXV; i++) tickDiv(0);
    pushExp(0, MAXV, "R9 counter at all-ones");
    pushExp(2, 0, "R9 no overflow before wrap");
    @(negedge clk); divEn[0] = 1'b1;
    @(negedge clk); divEn[0] = 1'b0;
    pushExp(0, 0, "R9 wrap to zero");
    pushExp(2, 1, "R9 overflow pulse on wrap cycle");
    @(negedge clk);
    pushExp(2, 0, "R9 overflow pulse lasts one cycle");

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule